// File: doc/BRIEF.md
# Port-Addressed I/O Peripheral Bus

This block sits on the device side of a byte-wide, port-mapped I/O bus driven by a small processor core. The core puts a port number on an 8-bit address bus and holds it for two clock cycles. In the second of those cycles it pulses a read or a write strobe. On a write, the word on the write-data bus goes into one of a bank of output latches. The latches drive the block's parallel output ports continuously. On a read, a multiplexer selects one of the parallel input ports and sends it back to the core on the read-data bus.

The read multiplexer is followed by a register. It samples the current address on every clock edge, whether or not a read is in progress. Because the address is already stable in the first cycle of an access, the selected byte is ready at the start of the second cycle, when the core captures it.

A parameter selects how the output side decodes addresses:
- **Full decode:** output port k answers to address k.
- **One-hot decode:** for small designs with at most eight outputs, output port k answers whenever address bit k is set. Each port then costs a single address bit of decoding.

Top module: `io_port_bus`

## Requirements
- R1: While reset is asserted, every output latch and the read-data register are 0x00.
- R2: In full-decode mode, a write strobe sampled high at address k (k below the output count) loads the write data into output port k at that clock edge. The new value is visible in the following cycle. Port k occupies bits [8k+7:8k] of the output bus.
- R3: An output latch keeps its value in any cycle in which the write strobe is low, even while the address selects it.
- R4: In full-decode mode, a write to an address at or above the output count changes no output port.
- R5: In one-hot mode, a write loads every output port k whose address bit k is 1. Address bits at or above the output count are ignored, and an address of 0x00 loads nothing.
- R6: The read data is the input port selected by the address at the previous clock edge. Input port k occupies bits [8k+7:8k] of the input bus. A change on an input port reaches the read data only after one register stage.
- R7: An address at or above the input count reads as 0x00.
- R8: When either strobe is high, the address (and for a write, the write data) equals its value at the previous edge. This is the two-cycle hold of the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_addr | input | 8 | Port number from the core |
| rd_stb | input | 1 | Read strobe, second cycle of an input access |
| wr_stb | input | 1 | Write strobe, second cycle of an output access |
| wr_data | input | 8 | Data for an output access |
| in_ports | input | N_IN*8 | Parallel input ports, port k in byte k |
| rd_data | output | 8 | Registered selected input byte |
| out_ports | output | N_OUT*8 | Output latches, port k in byte k |

## Verification
The assertions check four things on every cycle:
- every latch either captures on a matching strobe or holds;
- unmapped writes leave the full-decode bank unchanged;
- the read register follows the input port addressed one edge earlier, or 0x00;
- the two-cycle hold of the bus is respected.

Other properties can only be shown by the bench's scenarios. These are the decode mode itself (which ports a given address reaches, including multi-bit one-hot addresses), the value seen in the exact cycle the core samples the read, and the return to zero on a reset during operation.

// File: rtl/io_bus_pkg.sv
package io_bus_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/io_out_sel.sv
module io_out_sel
  import io_bus_pkg::*;
#(
  parameter int N_OUT  = 4,
  parameter bit ONEHOT = 1'b0
) (
  input  addr_t            addr,
  output logic [N_OUT-1:0] sel
);
  generate
    if (ONEHOT) begin : g_onehot
      for (genvar k = 0; k < N_OUT; k++) begin : g_bit
        assign sel[k] = addr[k];
      end
    end else begin : g_full
      for (genvar k = 0; k < N_OUT; k++) begin : g_cmp
        assign sel[k] = (addr == ADDR_W'(k));
      end
    end
  endgenerate
endmodule

// File: rtl/io_out_reg.sv
module io_out_reg
  import io_bus_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  byte_t d,
  output byte_t q
);
  byte_t q_nxt;

  always_comb begin
    q_nxt = q;
    if (we) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(d)));
  // R3
  hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/io_in_sel.sv
module io_in_sel
  import io_bus_pkg::*;
#(
  parameter int N_IN = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  addr_t                  addr,
  input  logic [N_IN*BYTE_W-1:0] in_flat,
  output byte_t                  rd_data
);
  localparam logic [ADDR_W:0] IN_LIM = (ADDR_W+1)'(N_IN);

  byte_t in_arr [N_IN];
  byte_t rd_nxt;

  generate
    for (genvar k = 0; k < N_IN; k++) begin : g_split
      assign in_arr[k] = in_flat[k*BYTE_W +: BYTE_W];
    end
  endgenerate

  always_comb begin
    rd_nxt = '0;
    for (int k = 0; k < N_IN; k++) begin
      if (addr == ADDR_W'(k)) rd_nxt = in_arr[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_nxt;
  end

  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, addr} >= IN_LIM) |=> (rd_data == '0));

  generate
    for (genvar k = 0; k < N_IN; k++) begin : g_rdchk
      // R6
      read_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(k)) |=> (rd_data == $past(in_arr[k])));
    end
  endgenerate
endmodule

// File: rtl/io_port_bus.sv
module io_port_bus
  import io_bus_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 4,
  parameter bit ONEHOT = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              port_addr,
  input  logic                    rd_stb,
  input  logic                    wr_stb,
  input  logic [7:0]              wr_data,
  input  logic [N_IN*BYTE_W-1:0]  in_ports,
  output logic [7:0]              rd_data,
  output logic [N_OUT*BYTE_W-1:0] out_ports
);
  localparam logic [ADDR_W:0] OUT_LIM = (ADDR_W+1)'(N_OUT);

  logic [N_OUT-1:0] sel;

  io_out_sel #(.N_OUT(N_OUT), .ONEHOT(ONEHOT)) u_sel (
    .addr (port_addr),
    .sel  (sel)
  );

  generate
    for (genvar k = 0; k < N_OUT; k++) begin : g_lat
      io_out_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_stb & sel[k]),
        .d     (wr_data),
        .q     (out_ports[k*BYTE_W +: BYTE_W])
      );
    end
  endgenerate

  io_in_sel #(.N_IN(N_IN)) u_in (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (port_addr),
    .in_flat (in_ports),
    .rd_data (rd_data)
  );

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> $stable(port_addr));
  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ($stable(port_addr) && $stable(wr_data)));

  generate
    if (!ONEHOT) begin : g_fullchk
      // R4
      unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && ({1'b0, port_addr} >= OUT_LIM)) |=> $stable(out_ports));
    end
  endgenerate
endmodule

// File: tb/tb_io_port_bus.sv
module tb_io_port_bus;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  port_addr = '0;
  logic        rd_stb = 1'b0;
  logic        wr_stb = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [31:0] in_ports = 32'hA3A2_A1A0;
  logic [7:0]  rd_data, rd_data_oh;
  logic [31:0] out_ports, out_ports_oh;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  io_port_bus #(.N_IN(4), .N_OUT(4), .ONEHOT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .wr_data(wr_data), .in_ports(in_ports),
    .rd_data(rd_data), .out_ports(out_ports));

  io_port_bus #(.N_IN(4), .N_OUT(4), .ONEHOT(1'b1)) dut_oh (
    .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .wr_data(wr_data), .in_ports(in_ports),
    .rd_data(rd_data_oh), .out_ports(out_ports_oh));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); port_addr = a; wr_data = d;
    @(negedge clk); wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] v, output logic [7:0] v_oh);
    @(negedge clk); port_addr = a;
    @(negedge clk); rd_stb = 1'b1; v = rd_data; v_oh = rd_data_oh;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  // {write, addr, data, expected (out_ports after write, or rd_data in low byte)}
  localparam logic [48:0] VEC [11] = '{
    {1'b1, 8'h00, 8'h11, 32'h0000_0011},   // R2
    {1'b1, 8'h03, 8'h33, 32'h3300_0011},   // R2
    {1'b1, 8'h01, 8'h5A, 32'h3300_5A11},   // R2
    {1'b1, 8'h07, 8'hFF, 32'h3300_5A11},   // R4
    {1'b1, 8'h04, 8'hEE, 32'h3300_5A11},   // R4 boundary
    {1'b0, 8'h00, 8'h00, 32'h0000_00A0},   // R6
    {1'b0, 8'h03, 8'h00, 32'h0000_00A3},   // R6
    {1'b0, 8'h04, 8'h00, 32'h0000_0000},   // R7 boundary
    {1'b0, 8'hFF, 8'h00, 32'h0000_0000},   // R7
    {1'b1, 8'h02, 8'hC3, 32'h33C3_5A11},   // R2
    {1'b0, 8'h01, 8'h00, 32'h0000_00A1}    // R6
  };

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v_oh;
    repeat (3) @(negedge clk);
    chk("R1 reset out", out_ports, 32'h0);
    chk("R1 reset rd", {24'h0, rd_data}, 32'h0);
    chk("R1 reset out onehot", out_ports_oh, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 11; i++) begin
      if (VEC[i][48]) begin
        do_write(VEC[i][47:40], VEC[i][39:32]);
        chk((VEC[i][47:40] < 8'd4) ? "R2 write" : "R4 unmapped write", out_ports, VEC[i][31:0]);
      end else begin
        do_read(VEC[i][47:40], v, v_oh);
        chk((VEC[i][47:40] < 8'd4) ? "R6 read" : "R7 empty read", {24'h0, v}, VEC[i][31:0]);
      end
    end

    // R3: address selects port 1, data differs, strobe low
    @(negedge clk); port_addr = 8'h01; wr_data = 8'h77;
    repeat (4) @(negedge clk);
    chk("R3 hold no strobe", out_ports, 32'h33C3_5A11);

    // R5: one-hot decode (bench state of dut_oh: earlier writes hit ports by bits)
    do_write(8'h00, 8'h42);
    chk("R5 zero address", out_ports_oh, out_ports_oh_before_zero());
    do_write(8'h05, 8'h9C);
    chk("R5 two bits", out_ports_oh & 32'h00FF_00FF, 32'h009C_009C);
    do_write(8'h08, 8'h55);
    chk("R5 bit3", out_ports_oh[31:24], 32'h55);
    do_write(8'h10, 8'hEE);
    chk("R5 high bit ignored", out_ports_oh & 32'hFF_FF_00_FF, 32'h559C_009C);

    // R6 register stage: input change seen one edge later
    @(negedge clk); port_addr = 8'h02;
    @(negedge clk); in_ports[23:16] = 8'h5F;
    #1 chk("R6 before edge", {24'h0, rd_data}, 32'hA2);
    @(negedge clk);
    chk("R6 after edge", {24'h0, rd_data}, 32'h5F);
    chk("R6 onehot read", {24'h0, rd_data_oh}, 32'h5F);

    // R1: reset during operation
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R1 mid reset out", out_ports, 32'h0);
    chk("R1 mid reset rd", {24'h0, rd_data}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // One-hot bank contents implied by the table writes before the zero-address write:
  // addr 00 writes nothing; 03 -> ports 0,1 = 33; 01 -> port 0 = 5A; 07 -> ports 0,1,2 = FF;
  // 04 -> port 2 = EE; 02 -> port 1 = C3.
  function automatic logic [31:0] out_ports_oh_before_zero();
    return 32'h00EE_C3FF;
  endfunction
endmodule